// File: doc/BRIEF.md
# Key-Protected Watchdog Timer with Early Warning

This block is a watchdog timer that sits on a simple memory-mapped register bus. A 12-bit down counter advances once per tick of a power-of-two prescaler. When the counter is already at zero and the next tick arrives, the block raises a one-cycle reset request and loads the counter again from the reload value. Software keeps the system alive by writing a reload key before that happens. Configuration is guarded. The prescaler, reload and early-warning fields accept writes only while a write-access key is the most recent key written. A separate start key arms the counter, and once armed it cannot be stopped except by reset.

The block also raises an early-warning interrupt. It fires when enabled and the counter steps onto a programmable threshold, which gives software time to react before the reset. The interrupt stays high until software writes one to an acknowledge bit. That bit needs no unlock, so a handler can read the control word, OR in the bit and write it back. Writes to the prescaler and reload registers reach the counter only after a fixed update delay. Two status bits show that an update is still in flight.

Top module: `keyed_wdog`

## Requirements
- R1: After reset: rst_req and early_irq are 0. Reads return 0 at offset 0x04 (prescaler code), 0xFFF at 0x08 (reload value), 0 at 0x0C (status) and 0 at 0x14 (early control).
- R2: Writes to 0x04, 0x08 and the threshold/enable fields of 0x14 take effect only while the most recent write to the key register (0x00, bits 15:0) was 0x5555. Any other key value, including 0xAAAA and 0xCCCC, withdraws that access. A rejected write leaves the read-back value unchanged.
- R3: Before key 0xCCCC is written, rst_req never pulses. After it, the counter runs, and later key writes of any value do not stop it.
- R4: Prescaler code c (bits 3:0 of 0x04) gives one tick every 2^(2+c) clock cycles. Codes whose divide would exceed 1024 are clamped to 1024.
- R5: With reload value R and divide D, rst_req is a one-cycle pulse (R+1)*D cycles after the start key's clock edge. The counter then restarts from R, so the pulses repeat every (R+1)*D cycles.
- R6: Writing key 0xAAAA reloads the counter from R and restarts the prescaler, so the next pulse comes (R+1)*D cycles after that write. If the reload falls in the same cycle as the expiring tick, the reload wins and no pulse is issued.
- R7: An accepted write to 0x04 sets status bit 0, and an accepted write to 0x08 sets status bit 1. Each bit is set for the 4 cycles after the write edge. The new value drives the counter only once the bit clears. The written value is readable at once.
- R8: With enable bit 15 of 0x14 set and threshold T in bits 11:0, early_irq rises when the counter steps to T. For T < R that is (R-T)*D cycles after start. It then stays high, across reset pulses, until acknowledged. With enable clear, it never rises.
- R9: Writing 1 to bit 14 of 0x14 clears early_irq in the next cycle, with or without write access. Without access, the threshold and enable are left unchanged. Bit 14 reads as 0. If an acknowledge and a new threshold hit fall in the same cycle, early_irq stays high.
- R10: Offset 0x10 reads as 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| early_irq | output | 1 | Early-warning interrupt, level, held until acknowledged |
| rst_req | output | 1 | One-cycle reset request on timeout |

## Verification
Two pairs of events can land on the same clock edge. The first pair is a reload key and the expiring tick at count zero. The second pair is an acknowledge write and the tick that steps the counter onto the threshold. The bench provokes each collision by counting cycles from the start edge with the arithmetic formulas (R+1)*D and (R-T)*D. It then issues the write so that its clock edge is exactly the edge computed for the event. For the reload collision, it checks that no pulse appears and that the next pulse comes a full period later. For the acknowledge collision, it checks that the interrupt is still high afterwards and that a later acknowledge clears it.

// File: rtl/keyed_wdog_pkg.sv
package keyed_wdog_pkg;

    localparam int BUS_AW = 5;
    localparam int BUS_DW = 32;

    localparam logic [BUS_AW-1:0] OFS_KEY   = 5'h00;
    localparam logic [BUS_AW-1:0] OFS_PSC   = 5'h04;
    localparam logic [BUS_AW-1:0] OFS_RLD   = 5'h08;
    localparam logic [BUS_AW-1:0] OFS_STAT  = 5'h0C;
    localparam logic [BUS_AW-1:0] OFS_WIN   = 5'h10;
    localparam logic [BUS_AW-1:0] OFS_EARLY = 5'h14;

    localparam int EARLY_EN_BIT  = 15;
    localparam int EARLY_ACK_BIT = 14;

    localparam logic [15:0] KEY_ACCESS = 16'h5555;
    localparam logic [15:0] KEY_KICK   = 16'hAAAA;
    localparam logic [15:0] KEY_ARM    = 16'hCCCC;

    typedef enum logic [2:0] {
        KEV_NONE,
        KEV_ACCESS,
        KEV_KICK,
        KEV_ARM,
        KEV_OTHER
    } key_evt_e;

    typedef struct packed {
        logic              wr;
        logic [BUS_AW-1:0] addr;
        logic [BUS_DW-1:0] data;
    } bus_req_t;

    function automatic key_evt_e decode_key(input logic [15:0] v);
        case (v)
            KEY_ACCESS: return KEV_ACCESS;
            KEY_KICK:   return KEV_KICK;
            KEY_ARM:    return KEV_ARM;
            default:    return KEV_OTHER;
        endcase
    endfunction

    function automatic int clamp_log(input int code, input int shift, input int max_log);
        int s;
        s = code + shift;
        return (s > max_log) ? max_log : s;
    endfunction

endpackage

// File: rtl/keyed_wdog_shadow.sv
module keyed_wdog_shadow #(
    parameter int W = 12,
    parameter int DELAY = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] shadow,
    output logic [W-1:0] active,
    output logic         pending
);
    localparam int DLY_W = $clog2(DELAY + 1);

    logic [DLY_W-1:0] dly;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= RST_VAL;
            active <= RST_VAL;
            dly    <= '0;
        end else if (we) begin
            shadow <= wdata;
            dly    <= DLY_W'(DELAY);
        end else if (dly != '0) begin
            dly <= dly - 1'b1;
            if (dly == DLY_W'(1)) active <= shadow;
        end
    end

    assign pending = (dly != '0);

    p_write_pends_r7: assert property (@(posedge clk) disable iff (rst)
        we |=> pending);
    p_active_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (pending && !we && $past(pending)) |=> (pending || active == shadow));
endmodule

// File: rtl/keyed_wdog_regs.sv
module keyed_wdog_regs
    import keyed_wdog_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int PSC_W = 4,
    parameter int UPD_DELAY = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  bus_req_t          req,
    output logic [BUS_DW-1:0] rdata,
    output key_evt_e          key_evt,
    output logic [PSC_W-1:0]  psc_active,
    output logic [CNT_W-1:0]  rld_active,
    output logic [CNT_W-1:0]  thr,
    output logic              early_en,
    output logic              ack
);
    logic             wr, unlocked;
    logic             psc_we, rld_we, early_we;
    logic [PSC_W-1:0] psc_sh;
    logic [CNT_W-1:0] rld_sh;
    logic             psc_pend, rld_pend;

    assign wr       = bus_sel && req.wr;
    assign key_evt  = (wr && req.addr == OFS_KEY) ? decode_key(req.data[15:0]) : KEV_NONE;
    assign psc_we   = wr && unlocked && req.addr == OFS_PSC;
    assign rld_we   = wr && unlocked && req.addr == OFS_RLD;
    assign early_we = wr && unlocked && req.addr == OFS_EARLY;
    assign ack      = wr && req.addr == OFS_EARLY && req.data[EARLY_ACK_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            unlocked <= 1'b0;
            thr      <= '0;
            early_en <= 1'b0;
        end else begin
            if (key_evt != KEV_NONE) unlocked <= (key_evt == KEV_ACCESS);
            if (early_we) begin
                thr      <= req.data[CNT_W-1:0];
                early_en <= req.data[EARLY_EN_BIT];
            end
        end
    end

    keyed_wdog_shadow #(.W(PSC_W), .DELAY(UPD_DELAY), .RST_VAL('0)) psc_sh_i (
        .clk(clk), .rst(rst), .we(psc_we), .wdata(req.data[PSC_W-1:0]),
        .shadow(psc_sh), .active(psc_active), .pending(psc_pend)
    );

    keyed_wdog_shadow #(.W(CNT_W), .DELAY(UPD_DELAY), .RST_VAL({CNT_W{1'b1}})) rld_sh_i (
        .clk(clk), .rst(rst), .we(rld_we), .wdata(req.data[CNT_W-1:0]),
        .shadow(rld_sh), .active(rld_active), .pending(rld_pend)
    );

    always_comb begin
        rdata = '0;
        case (req.addr)
            OFS_PSC:   rdata = BUS_DW'(psc_sh);
            OFS_RLD:   rdata = BUS_DW'(rld_sh);
            OFS_STAT:  rdata = BUS_DW'({rld_pend, psc_pend});
            OFS_EARLY: begin
                rdata[CNT_W-1:0]    = thr;
                rdata[EARLY_EN_BIT] = early_en;
            end
            default:   rdata = '0;
        endcase
    end

    p_locked_psc_r2: assert property (@(posedge clk) disable iff (rst)
        !unlocked |=> $stable(psc_sh));
    p_locked_rld_r2: assert property (@(posedge clk) disable iff (rst)
        !unlocked |=> $stable(rld_sh));
endmodule

// File: rtl/keyed_wdog_prescale.sv
module keyed_wdog_prescale
    import keyed_wdog_pkg::*;
#(
    parameter int PSC_W = 4,
    parameter int PSC_SHIFT = 2,
    parameter int MAX_LOG = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [PSC_W-1:0] code,
    output logic             tick
);
    localparam int LOG_W = $clog2(MAX_LOG + 1);

    logic [MAX_LOG-1:0] pcnt, mask;
    logic [LOG_W-1:0]   div_log;

    always_comb begin
        div_log = LOG_W'(clamp_log(int'(code), PSC_SHIFT, MAX_LOG));
        mask    = {MAX_LOG{1'b1}} >> (LOG_W'(MAX_LOG) - div_log);
    end

    assign tick = run && (pcnt >= mask);

    always_ff @(posedge clk) begin
        if (rst || restart) pcnt <= '0;
        else if (run)       pcnt <= tick ? '0 : pcnt + 1'b1;
    end

    p_tick_gap_r4: assert property (@(posedge clk) disable iff (rst)
        (tick && !restart) |=> !tick);
    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        !run |-> !tick);
endmodule

// File: rtl/keyed_wdog_counter.sv
module keyed_wdog_counter
    import keyed_wdog_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  key_evt_e         key_evt,
    input  logic             tick,
    input  logic [CNT_W-1:0] rld,
    input  logic [CNT_W-1:0] thr,
    input  logic             early_en,
    input  logic             ack,
    output logic             running,
    output logic             restart,
    output logic             early_irq,
    output logic             rst_req
);
    logic             arm, kick, step, expire, hit;
    logic [CNT_W-1:0] cnt, step_val;

    assign arm      = (key_evt == KEV_ARM) && !running;
    assign kick     = (key_evt == KEV_KICK);
    assign restart  = arm || kick;
    assign step     = running && tick && !kick;
    assign expire   = step && (cnt == '0);
    assign step_val = (cnt == '0) ? rld : cnt - 1'b1;
    assign hit      = step && early_en && (step_val == thr);

    always_ff @(posedge clk) begin
        if (rst) begin
            running   <= 1'b0;
            cnt       <= '1;
            rst_req   <= 1'b0;
            early_irq <= 1'b0;
        end else begin
            rst_req <= expire;
            if (arm) running <= 1'b1;
            if (restart)   cnt <= rld;
            else if (step) cnt <= step_val;
            if (hit)      early_irq <= 1'b1;
            else if (ack) early_irq <= 1'b0;
        end
    end

    p_run_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        running |=> running);
    p_no_req_idle_r3: assert property (@(posedge clk) disable iff (rst)
        !running |-> !rst_req);
    p_pulse_single_r5: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);
    p_kick_no_req_r6: assert property (@(posedge clk) disable iff (rst)
        kick |=> !rst_req);
    p_irq_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (early_irq && !ack) |=> early_irq);
    p_irq_clear_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(early_irq) |-> $past(ack));
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
    import keyed_wdog_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int PSC_W = 4,
    parameter int PSC_SHIFT = 2,
    parameter int PSC_MAX_LOG = 10,
    parameter int UPD_DELAY = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        early_irq,
    output logic        rst_req
);
    bus_req_t         req;
    key_evt_e         key_evt;
    logic [PSC_W-1:0] psc_active;
    logic [CNT_W-1:0] rld_active, thr;
    logic             early_en, ack, running, restart, tick;

    assign req = '{wr: bus_wr, addr: bus_addr, data: bus_wdata};

    keyed_wdog_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W), .UPD_DELAY(UPD_DELAY)) regs_i (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .req(req), .rdata(bus_rdata),
        .key_evt(key_evt), .psc_active(psc_active), .rld_active(rld_active),
        .thr(thr), .early_en(early_en), .ack(ack)
    );

    keyed_wdog_prescale #(.PSC_W(PSC_W), .PSC_SHIFT(PSC_SHIFT), .MAX_LOG(PSC_MAX_LOG)) psc_i (
        .clk(clk), .rst(rst), .run(running), .restart(restart),
        .code(psc_active), .tick(tick)
    );

    keyed_wdog_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk(clk), .rst(rst), .key_evt(key_evt), .tick(tick), .rld(rld_active),
        .thr(thr), .early_en(early_en), .ack(ack), .running(running),
        .restart(restart), .early_irq(early_irq), .rst_req(rst_req)
    );
endmodule

// File: tb/keyed_wdog_tb_top.sv
`timescale 1ns/1ps
module keyed_wdog_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        early_irq, rst_req;

    int checks = 0, failures = 0, pulses = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    keyed_wdog dut_i (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .early_irq(early_irq), .rst_req(rst_req)
    );

    always @(negedge clk) if (!rst && rst_req) pulses++;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; bus_sel = 1'b0; bus_wr = 1'b0;
        idle(3);
        rst = 1'b0;
    endtask

    // called at a negedge; write takes place on the next posedge; returns at the following negedge
    task automatic bwrite(input logic [4:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bread(input logic [4:0] a, output int d);
        bus_addr = a;
        #1;
        d = int'(bus_rdata);
    endtask

    task automatic wait_req(output int n);
        n = 0;
        while (!rst_req && n < 20000) begin @(negedge clk); n++; end
    endtask

    task automatic wait_irq(output int n);
        n = 0;
        while (!early_irq && n < 20000) begin @(negedge clk); n++; end
    endtask

    task automatic setup(input int code, input int rld);
        do_reset();
        bwrite(5'h00, 32'h5555);
        bwrite(5'h04, code);
        bwrite(5'h08, rld);
        idle(6);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int v, n, p0;
        do_reset();
        // R1 reset state
        check("R1 rst_req", rst_req, 0);
        check("R1 early_irq", early_irq, 0);
        bread(5'h04, v); check("R1 psc", v, 0);
        bread(5'h08, v); check("R1 rld", v, 'hFFF);
        bread(5'h0C, v); check("R1 stat", v, 0);
        bread(5'h14, v); check("R1 early", v, 0);

        // R2 key protection
        bwrite(5'h04, 3);  bread(5'h04, v); check("R2 locked psc", v, 0);
        bwrite(5'h08, 5);  bread(5'h08, v); check("R2 locked rld", v, 'hFFF);
        bwrite(5'h14, 32'h8007); bread(5'h14, v); check("R2 locked early", v, 0);
        bwrite(5'h00, 32'h5555);
        bwrite(5'h08, 7);  bread(5'h08, v); check("R2 unlocked rld", v, 7);
        bwrite(5'h00, 32'h1234);
        bwrite(5'h08, 9);  bread(5'h08, v); check("R2 other key relocks", v, 7);
        bwrite(5'h00, 32'h5555);
        bwrite(5'h00, 32'hAAAA);
        bwrite(5'h04, 2);  bread(5'h04, v); check("R2 kick key relocks", v, 0);

        // R10 window offset
        bwrite(5'h00, 32'h5555);
        bwrite(5'h10, 32'hFFF); bread(5'h10, v); check("R10 window reads zero", v, 0);

        // R3 no pulse before arming, cannot be stopped
        setup(0, 0);
        p0 = pulses; idle(200);
        check("R3 idle no pulse", pulses - p0, 0);
        bwrite(5'h00, 32'hCCCC);
        wait_req(n); check("R3 armed first pulse", n, 4);
        bwrite(5'h00, 32'h5555); bwrite(5'h00, 32'h0000);
        p0 = pulses; idle(40);
        check("R3 still running after keys", pulses - p0, 10);

        // R4/R5 sweep of prescaler code and reload value
        for (int c = 0; c < 10; c++) begin
            for (int k = 0; k < 3; k++) begin
                int r, d;
                r = (k == 0) ? 0 : (k == 1) ? 2 : 5;
                d = 1 << (((c + 2) > 10) ? 10 : (c + 2));
                setup(c, r);
                bwrite(5'h00, 32'hCCCC);
                wait_req(n); check($sformatf("R4 R5 first c=%0d r=%0d", c, r), n, (r + 1) * d);
                @(negedge clk); check("R5 pulse width", rst_req, 0);
                n = 1;
                while (!rst_req && n < 20000) begin @(negedge clk); n++; end
                check($sformatf("R5 period c=%0d r=%0d", c, r), n, (r + 1) * d);
            end
        end

        // R6 reload key mid-run and coinciding with expiry
        setup(0, 3);
        bwrite(5'h00, 32'hCCCC);
        idle(9); bwrite(5'h00, 32'hAAAA);
        wait_req(n); check("R6 kick mid-run", n, 16);
        setup(0, 3);
        bwrite(5'h00, 32'hCCCC);
        p0 = pulses;
        idle(15); bwrite(5'h00, 32'hAAAA);
        check("R6 collision no pulse", pulses - p0, 0);
        wait_req(n); check("R6 collision next pulse", n, 16);

        // R7 pending flags and delayed effect
        do_reset();
        bwrite(5'h00, 32'h5555);
        bwrite(5'h04, 1);
        bread(5'h0C, v); check("R7 psc pending", v, 1);
        bread(5'h04, v); check("R7 psc readback", v, 1);
        idle(3); bread(5'h0C, v); check("R7 psc pending cycle 3", v, 1);
        idle(1); bread(5'h0C, v); check("R7 psc pending cleared", v, 0);
        bwrite(5'h08, 1); idle(6);
        bwrite(5'h08, 3);
        bread(5'h0C, v); check("R7 rld pending", v, 2);
        bwrite(5'h00, 32'hCCCC);
        wait_req(n); check("R7 old reload used", n, 16);
        @(negedge clk); n = 1;
        while (!rst_req && n < 20000) begin @(negedge clk); n++; end
        check("R7 new reload used", n, 32);

        // R8 threshold sweep
        for (int t = 0; t < 10; t++) begin
            setup(0, 10);
            bwrite(5'h14, 32'h8000 | t);
            bwrite(5'h00, 32'hCCCC);
            wait_irq(n); check($sformatf("R8 irq t=%0d", t), n, (10 - t) * 4);
        end
        wait_req(n); @(negedge clk);
        check("R8 irq held across pulse", early_irq, 1);
        setup(0, 10);
        bwrite(5'h14, 32'h0004);
        bwrite(5'h00, 32'hCCCC);
        idle(100); check("R8 disabled no irq", early_irq, 0);

        // R9 acknowledge
        setup(0, 10);
        bwrite(5'h14, 32'h8004);
        bwrite(5'h00, 32'hCCCC);
        wait_irq(n);
        bread(5'h14, v);
        bwrite(5'h14, v | 32'h4000);
        check("R9 ack clears", early_irq, 0);
        bread(5'h14, v); check("R9 cfg kept, ack reads 0", v, 'h8004);
        setup(0, 10);
        bwrite(5'h14, 32'h8004);
        bwrite(5'h00, 32'hCCCC);
        idle(23); bwrite(5'h14, 32'h4000);
        check("R9 set beats ack", early_irq, 1);
        bread(5'h14, v); check("R9 locked ack leaves cfg", v, 'h8004);
        bwrite(5'h14, 32'h4000);
        check("R9 second ack clears", early_irq, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule